// File: doc/BRIEF.md
# Fetch Address Counter

This block holds the address of the next instruction fetch. It only ever points at even byte addresses and moves forward two bytes at a time. Internally it stores a 15-bit word index and a unit counter steps that index. The byte address is the index with a zero appended below it. A jump writes a new address from the result bus. While a long instruction runs, the sequencer raises the step input on each half-cycle clock, so the counter moves once per clock. There is no post-update path.

Two conditions raise a fault. The first is a jump target with its lowest bit set. The second is a step that carries past the top of the address space. That carry sets a hidden seventeenth bit. The hidden bit stays set until the next load or reset. A fault is raised only on the step that first sets the hidden bit, so further passes over the top stay quiet until a load clears it. The fault output is sticky. It drops only on reset or on an explicit clear. A new fault event in the same cycle as a clear wins over the clear.

Top module: `fetch_addr_counter`

## Requirements
- R1: While rst_n is low, pc_addr reads 0000h and fault_o reads 0.
- R2: A clock edge with step_en high and load_en low makes pc_addr equal to its previous value plus 2, modulo 2^16.
- R3: A clock edge with both step_en and load_en low leaves pc_addr unchanged.
- R4: A clock edge with load_en high makes pc_addr equal to load_data with bit 0 forced to 0, whatever step_en is. The load wins over a step in the same cycle.
- R5: Bit 0 of pc_addr is 0 at all times.
- R6: A load whose load_data bit 0 is 1 sets fault_o at the same clock edge that stores the address.
- R7: A step from pc_addr FFFEh gives 0000h. If the hidden overflow bit was clear, fault_o is set at that edge and the hidden bit is set.
- R8: fault_o stays 1 until reset or a clock edge with fault_clr high. Such an edge clears it unless a new fault event happens in the same cycle.
- R9: A new fault event (R6 or R7) in the same cycle as fault_clr leaves fault_o at 1.
- R10: While the hidden bit is set, later steps across FFFEh do not set fault_o. A load clears the hidden bit, so the next crossing faults again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Write load_data as the new address (jump) |
| load_data | input | 16 | Jump target from the result bus |
| step_en | input | 1 | Advance the address by two bytes |
| fault_clr | input | 1 | Clear the sticky fault flag |
| pc_addr | output | 16 | Current fetch byte address, always even |
| fault_o | output | 1 | Sticky fault: misaligned load or overflow |

## Verification
Random stimulus mixes steps, holds and clears with loads. Some loads are random and some land just below FFFEh, which forces frequent crossings of the top. These cycles separate the step path from the hold path, and check that a load wins over a step. They also set the misaligned-load fault against the overflow fault. Directed cases cover load and clear in the same cycle, and a clear that loses to an overflow. A full second pass over the top without a load shows that the hidden bit suppresses a second fault. A reload before the next crossing shows that the fault comes back.

// File: rtl/fac_pkg.sv
package fac_pkg;

  // Operation chosen for the address register in a cycle
  typedef enum logic [1:0] {
    FAC_HOLD = 2'd0,
    FAC_STEP = 2'd1,
    FAC_LOAD = 2'd2
  } fac_op_e;

  // A jump write takes priority over an advance in the same cycle
  function automatic fac_op_e fac_pick_op(input logic load, input logic step);
    if (load)      return FAC_LOAD;
    else if (step) return FAC_STEP;
    else           return FAC_HOLD;
  endfunction

  // Fault set beats clear; otherwise clear drops the flag, else it holds
  function automatic logic fac_flag_next(input logic cur, input logic set,
                                         input logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

endpackage

// File: rtl/fac_step_unit.sv
// Unit counter on the word index (byte address shifted down by one)
module fac_step_unit #(
  parameter int WORD_W = 15
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              hidden_i,
  output logic [WORD_W-1:0] word_o,
  output logic              hidden_o,
  output logic              wrap_o
);

  function automatic logic [WORD_W:0] fac_bump(input logic [WORD_W-1:0] w);
    return {1'b0, w} + {{WORD_W{1'b0}}, 1'b1};
  endfunction

  logic [WORD_W:0] sum;
  logic            carry;

  always_comb begin
    sum      = fac_bump(word_i);
    carry    = sum[WORD_W];
    word_o   = sum[WORD_W-1:0];
    hidden_o = hidden_i | carry;
    // Only the carry that first sets the hidden bit counts as an overflow
    wrap_o   = carry & ~hidden_i;
  end

endmodule

// File: rtl/fac_load_align.sv
// Splits a jump target into its word index and an odd-address indication
module fac_load_align #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] data_i,
  output logic [ADDR_W-2:0] word_o,
  output logic              odd_o
);

  always_comb begin
    word_o = data_i[ADDR_W-1:1];
    odd_o  = data_i[0];
  end

endmodule

// File: rtl/fac_fault_flag.sv
// Sticky fault flag: set wins over clear
module fac_fault_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  import fac_pkg::*;

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= fac_flag_next(flag_q, set_i, clr_i);
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/fetch_addr_counter.sv
module fetch_addr_counter #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_data,
  input  logic              step_en,
  input  logic              fault_clr,
  output logic [ADDR_W-1:0] pc_addr,
  output logic              fault_o
);

  import fac_pkg::*;

  localparam int WORD_W = ADDR_W - 1;

  // Stored state: word index plus hidden overflow bit
  logic [WORD_W-1:0] word_q;
  logic              hidden_q;

  // Named internal events
  fac_op_e           op;
  logic [WORD_W-1:0] step_word;
  logic              step_hidden;
  logic              step_wrap;
  logic [WORD_W-1:0] load_word;
  logic              load_odd;
  logic              ovf_evt;
  logic              odd_evt;
  logic              fault_set;

  assign op = fac_pick_op(load_en, step_en);

  fac_step_unit #(.WORD_W(WORD_W)) u_step (
    .word_i   (word_q),
    .hidden_i (hidden_q),
    .word_o   (step_word),
    .hidden_o (step_hidden),
    .wrap_o   (step_wrap)
  );

  fac_load_align #(.ADDR_W(ADDR_W)) u_align (
    .data_i (load_data),
    .word_o (load_word),
    .odd_o  (load_odd)
  );

  assign odd_evt   = (op == FAC_LOAD) & load_odd;
  assign ovf_evt   = (op == FAC_STEP) & step_wrap;
  assign fault_set = odd_evt | ovf_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      hidden_q <= 1'b0;
    end else begin
      unique case (op)
        FAC_LOAD: begin
          word_q   <= load_word;
          hidden_q <= 1'b0;
        end
        FAC_STEP: begin
          word_q   <= step_word;
          hidden_q <= step_hidden;
        end
        default: begin
          word_q   <= word_q;
          hidden_q <= hidden_q;
        end
      endcase
    end
  end

  fac_fault_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (fault_set),
    .clr_i  (fault_clr),
    .flag_o (fault_o)
  );

  assign pc_addr = {word_q, 1'b0};

endmodule

// File: rtl/fac_checker.sv
module fac_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_en,
  input logic [ADDR_W-1:0] load_data,
  input logic              step_en,
  input logic              fault_clr,
  input logic [ADDR_W-1:0] pc_addr,
  input logic              fault_o,
  input logic              hidden_q,
  input logic              ovf_evt,
  input logic              odd_evt
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] TWO      = ADDR_W'(2);

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en) |=> pc_addr == $past(pc_addr) + TWO); // R2

  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !load_en) |=> $stable(pc_addr)); // R3

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> pc_addr == {$past(load_data[ADDR_W-1:1]), 1'b0}); // R4

  AST_MISALIGN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && load_data[0]) |=> fault_o); // R6

  AST_TOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && pc_addr == TOP_ADDR && !hidden_q)
      |=> (fault_o && pc_addr == '0)); // R7

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !fault_clr) |=> fault_o); // R8

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_clr && !ovf_evt && !odd_evt) |=> !fault_o); // R8

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_clr && (ovf_evt || odd_evt)) |=> fault_o); // R9

  AST_NO_REFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (hidden_q && step_en && !load_en && !fault_o) |=> !fault_o); // R10

endmodule

bind fetch_addr_counter fac_checker #(.ADDR_W(ADDR_W)) u_fac_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_en   (load_en),
  .load_data (load_data),
  .step_en   (step_en),
  .fault_clr (fault_clr),
  .pc_addr   (pc_addr),
  .fault_o   (fault_o),
  .hidden_q  (hidden_q),
  .ovf_evt   (ovf_evt),
  .odd_evt   (odd_evt)
);

// File: tb/fetch_addr_counter_bench.sv
`timescale 1ns/1ps
module fetch_addr_counter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [15:0] load_data = '0;
  logic        step_en = 1'b0;
  logic        fault_clr = 1'b0;
  logic [15:0] pc_addr;
  logic        fault_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // Reference state
  logic [15:0] exp_pc = '0;
  logic        exp_hid = 1'b0;
  logic        exp_fault = 1'b0;

  always #2.5 clk = ~clk;

  fetch_addr_counter u_fetch_addr_counter (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
    .step_en(step_en), .fault_clr(fault_clr), .pc_addr(pc_addr), .fault_o(fault_o)
  );

  // Byte-address arithmetic: +2 on the full 17-bit value
  function automatic logic [16:0] ref_add2(input logic [15:0] a);
    return {1'b0, a} + 17'd2;
  endfunction

  task automatic ref_update(input logic ld, input logic [15:0] d,
                            input logic st, input logic cl);
    logic        ev;
    logic [16:0] s;
    ev = 1'b0;
    if (ld) begin
      ev      = d[0];
      exp_pc  = d & 16'hFFFE;
      exp_hid = 1'b0;
    end else if (st) begin
      s       = ref_add2(exp_pc);
      ev      = s[16] & ~exp_hid;
      exp_hid = exp_hid | s[16];
      exp_pc  = s[15:0];
    end
    if (ev)      exp_fault = 1'b1;
    else if (cl) exp_fault = 1'b0;
  endtask

  task automatic check(input string tag);
    vectors++;
    if (pc_addr !== exp_pc) begin
      miscompares++;
      $display("FAIL %s pc_addr actual=%h expected=%h", tag, pc_addr, exp_pc);
    end
    vectors++;
    if (fault_o !== exp_fault) begin
      miscompares++;
      $display("FAIL %s fault_o actual=%b expected=%b", tag, fault_o, exp_fault);
    end
    vectors++;
    if (pc_addr[0] !== 1'b0) begin
      miscompares++;
      $display("FAIL R5 pc_addr[0] actual=%b expected=0", pc_addr[0]);
    end
  endtask

  task automatic apply(input logic ld, input logic [15:0] d, input logic st,
                       input logic cl, input string tag);
    @(negedge clk);
    load_en = ld; load_data = d; step_en = st; fault_clr = cl;
    @(posedge clk);
    ref_update(ld, d, st, cl);
    #1;
    check(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED_0A11);
    // R1: reset state, with inputs active during reset
    load_en = 1'b1; load_data = 16'h1235; step_en = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1");
    @(negedge clk);
    load_en = 1'b0; step_en = 1'b0;
    rst_n = 1'b1;

    // R3: hold
    apply(1'b0, 16'h0000, 1'b0, 1'b0, "R3");
    apply(1'b0, 16'hFFFF, 1'b0, 1'b0, "R3");
    // R2: steps
    for (int i = 0; i < 4; i++) apply(1'b0, 16'h0000, 1'b1, 1'b0, "R2");
    // R4: load wins over step
    apply(1'b1, 16'h4A3C, 1'b1, 1'b0, "R4");
    apply(1'b0, 16'h0000, 1'b1, 1'b0, "R2");
    // R6: misaligned load, bit 0 dropped
    apply(1'b1, 16'h7777, 1'b0, 1'b0, "R6");
    // R8: sticky, then clear
    apply(1'b0, 16'h0000, 1'b1, 1'b0, "R8");
    apply(1'b0, 16'h0000, 1'b0, 1'b1, "R8");
    // R9: misaligned load and clear together
    apply(1'b1, 16'h0101, 1'b0, 1'b1, "R9");
    apply(1'b0, 16'h0000, 1'b0, 1'b1, "R8");
    // R7: cross the top, with clear in the same cycle (R9)
    apply(1'b1, 16'hFFFC, 1'b0, 1'b0, "R4");
    apply(1'b0, 16'h0000, 1'b1, 1'b0, "R2");
    apply(1'b0, 16'h0000, 1'b1, 1'b1, "R7");
    apply(1'b0, 16'h0000, 1'b0, 1'b1, "R8");
    // R10: full second pass with no load, no new fault
    for (int i = 0; i < 32768; i++) apply(1'b0, 16'h0000, 1'b1, 1'b0, "R10");
    apply(1'b0, 16'h0000, 1'b0, 1'b0, "R10");
    // R10: reload clears hidden bit, next crossing faults again
    apply(1'b1, 16'hFFFC, 1'b0, 1'b0, "R10");
    apply(1'b0, 16'h0000, 1'b1, 1'b0, "R10");
    apply(1'b0, 16'h0000, 1'b1, 1'b0, "R10");

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic        ld, st, cl;
      logic [15:0] d;
      ld = ($urandom_range(0, 5) == 0);
      st = ($urandom_range(0, 3) != 0);
      cl = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 3) == 0)
        d = 16'hFFF0 | 16'($urandom_range(0, 15));
      else
        d = 16'($urandom);
      apply(ld, d, st, cl, "R2/R4/R6/R7/R8 random");
    end
    finish_run();
  end

endmodule